// File: doc/BRIEF.md
# Paged EPROM Boot Loader Sequencer

This block fills a 24-bit internal program RAM from a byte-wide external EPROM. It runs on its own after reset, and it runs again whenever software sets a force bit. Each boot uses one of eight 8 KiB pages. The first access reads a length byte L, which gives the number of words to load, N = 8*(L+1). The block then walks the page from its top downward, so a short program boots in fewer accesses. It reads three bytes for each word, joins them into one word and writes that word to the RAM through a plain write port, one word per cycle pulse.

Every EPROM access drives the boot strobe for a programmable number of wait cycles. The 16-bit byte address is split across two buses: the low bits go out on the address bus and the top bits go out on the two most significant data-bus lines. Between bytes the block watches a bus request. When a request is present it parks in a granted state and leaves the external bus free until the request goes away.

The controller has six states:
- IDLE. A request moves it to GRANT and a pending force moves it to FETCH_LEN. The request wins when both are present.
- FETCH_LEN reads the length byte. When its wait count runs out it moves to FETCH_BYTE, or to GRANT if a request is present.
- FETCH_BYTE reads one byte. After the third byte of a word it moves to WRITE, otherwise it stays in FETCH_BYTE. Either way it goes to GRANT first if a request is present.
- WRITE stores the word. It moves to FETCH_BYTE, or to FINISH after word 0.
- GRANT returns to the state it interrupted once the request is released.
- FINISH always returns to IDLE.

Top module: `boot_page_loader`

## Requirements
- R1: During reset and after it, the strobe, the grant, the RAM write and done are all low. force_o reads 1, the wait setting is 7 and the page setting is 0, so a boot of page 0 with 8-cycle strobes starts without any software action.
- R2: The first access of every boot reads byte offset 0 of the selected page. That byte is the length L, and the boot then loads N = 8*(L+1) words.
- R3: After the length byte, words i = N-1 down to 0 are read in turn. For each word the offsets are 4i+3, then 4i+2, then 4i+1. Offset 4i is never read for program data, and a boot makes exactly 1+3N accesses.
- R4: The byte address is page*8192 + offset. Bits 13:0 go out on ext_addr_o and bits 15:14 go out on ext_dhi_o. Both buses read 0 while the strobe is low.
- R5: A byte is taken from bus_din_i[15:8] in the last strobe cycle of its access. Word i is written to RAM address i. Its bits 23:16 come from offset 4i+1, bits 15:8 from 4i+2 and bits 7:0 from 4i+3.
- R6: Each access holds ext_strobe_o high for W+1 consecutive cycles with a stable address. W is the wait setting, from 0 to 7.
- R7: A configuration write (cfg_we_i) with cfg_force_i=1 stores cfg_page_i and cfg_wait_i and sets force_o from the next cycle on. A boot of the new page then starts.
- R8: After the last word, done_o is high for exactly one cycle and force_o reads 0 afterwards. The exception is a new force write landing in that same cycle.
- R9: A request that arrives during an access is granted only after that byte completes. bus_gnt_o rises in the cycle after the completion, and the strobe and the grant are never high together.
- R10: bus_gnt_o falls in the cycle after bus_req_i is sampled low. The load resumes with the strobe in that same cycle, and the RAM content at the end is the same as for a boot without a request.
- R11: While idle, a request is granted from the next cycle and no boot starts.
- R12: ram_we_o pulses last a single cycle and never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wait_i | input | 3 | Wait cycles per access |
| cfg_page_i | input | 3 | Page to load on a forced boot |
| cfg_force_i | input | 1 | Force bit; 1 requests a boot |
| force_o | output | 1 | Force bit state; clears when a boot finishes |
| bus_req_i | input | 1 | External bus request |
| bus_gnt_o | output | 1 | External bus grant |
| ext_strobe_o | output | 1 | Boot memory strobe, active high |
| ext_addr_o | output | 14 | Byte address bits 13:0 |
| ext_dhi_o | output | 2 | Byte address bits 15:14, driven on data bus bits 23:22 |
| bus_din_i | input | 24 | External data bus; bits 15:8 carry the EPROM byte |
| ram_we_o | output | 1 | Program RAM write enable |
| ram_addr_o | output | 11 | Program RAM word address |
| ram_wdata_o | output | 24 | Program RAM write data |
| done_o | output | 1 | One-cycle pulse when a boot ends |

## Verification
Two events can fall in the same cycle: a byte access finishing its last wait cycle and a new bus request arriving. The bench provokes this on purpose. It waits for the strobe to rise after a word write, counts off the wait setting and raises the request exactly in the final strobe cycle. The result is judged by four checks: the grant appears in the next cycle with the strobe low; the interrupted access still showed its full strobe width; the fetch resumes in the cycle the request drops; and every word written afterwards matches the bytes computed from the bench's ROM function.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam int WORD_W         = 24;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int SLOT_W         = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LEN,
        ST_FETCH_BYTE,
        ST_WRITE,
        ST_GRANT,
        ST_FINISH
    } boot_state_e;
endpackage

// File: rtl/boot_cfg_regs.sv
module boot_cfg_regs #(
    parameter int PAGE_W = 3,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WAIT_W-1:0] wr_wait_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic              wr_force_i,
    input  logic              clr_force_i,
    output logic [WAIT_W-1:0] wait_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              force_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q  <= '1;
            page_q  <= '0;
            force_q <= 1'b1;
        end else begin
            if (wr_en_i) begin
                wait_q <= wr_wait_i;
                page_q <= wr_page_i;
            end
            if (wr_en_i && wr_force_i)
                force_q <= 1'b1;
            else if (clr_force_i)
                force_q <= 1'b0;
        end
    end

    // R8
    force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_force_i && !wr_en_i) |=> !force_q);
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
    parameter int PAGE_W = 3,
    parameter int IDX_W  = 11,
    parameter int SLOT_W = 2,
    parameter int ABUS_W = 14,
    parameter int HI_W   = 2
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              len_phase_i,
    input  logic              active_i,
    output logic [ABUS_W-1:0] addr_o,
    output logic [HI_W-1:0]   hi_o
);
    localparam int OFS_W = IDX_W + SLOT_W;
    localparam int BA_W  = PAGE_W + OFS_W;

    logic [SLOT_W-1:0] lane_ofs;
    logic [OFS_W-1:0]  ofs;
    logic [BA_W-1:0]   baddr;

    always_comb begin
        lane_ofs = {SLOT_W{1'b1}} - slot_i;
        ofs      = len_phase_i ? '0 : {idx_i, lane_ofs};
        baddr    = active_i ? {page_i, ofs} : '0;
    end

    assign addr_o = baddr[ABUS_W-1:0];
    assign hi_o   = baddr[BA_W-1 -: HI_W];
endmodule

// File: rtl/boot_word_asm.sv
module boot_word_asm
    import boot_pkg::*;
#(
    parameter int NLANE = BYTES_PER_WORD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en_i,
    input  logic [SLOT_W-1:0]       slot_i,
    input  logic [BYTE_W-1:0]       byte_i,
    output logic [NLANE*BYTE_W-1:0] word_o
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (cap_en_i && slot_i == SLOT_W'(g))
                lane_q <= byte_i;
        end
        assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_i |-> (slot_i < SLOT_W'(NLANE)));
endmodule

// File: rtl/boot_page_loader.sv
module boot_page_loader
    import boot_pkg::*;
#(
    parameter int PAGE_W   = 3,
    parameter int WPL_W    = 3,
    parameter int ABUS_W   = 14,
    parameter int DBUS_W   = 24,
    parameter int DLANE_LO = 8,
    parameter int WAIT_W   = 3,
    localparam int IDX_W   = BYTE_W + WPL_W,
    localparam int BADDR_W = PAGE_W + IDX_W + SLOT_W,
    localparam int HI_W    = BADDR_W - ABUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    input  logic [PAGE_W-1:0] cfg_page_i,
    input  logic              cfg_force_i,
    output logic              force_o,
    input  logic              bus_req_i,
    output logic              bus_gnt_o,
    output logic              ext_strobe_o,
    output logic [ABUS_W-1:0] ext_addr_o,
    output logic [HI_W-1:0]   ext_dhi_o,
    input  logic [DBUS_W-1:0] bus_din_i,
    output logic              ram_we_o,
    output logic [IDX_W-1:0]  ram_addr_o,
    output logic [WORD_W-1:0] ram_wdata_o,
    output logic              done_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BYTES_PER_WORD - 1);

    boot_state_e       state_q, state_d, ret_q, ret_d;
    logic [WAIT_W-1:0] wait_q, wcnt_q;
    logic [PAGE_W-1:0] page_q, page_act_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SLOT_W-1:0] slot_q;
    logic              force_q, len_phase, fetching, acc_done;
    logic [BYTE_W-1:0] rd_byte;

    assign rd_byte  = bus_din_i[DLANE_LO +: BYTE_W];
    assign fetching = (state_q == ST_FETCH_LEN) || (state_q == ST_FETCH_BYTE);
    assign acc_done = fetching && (wcnt_q == '0);
    assign force_o  = force_q;

    boot_cfg_regs #(.PAGE_W(PAGE_W), .WAIT_W(WAIT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(cfg_we_i), .wr_wait_i(cfg_wait_i), .wr_page_i(cfg_page_i),
        .wr_force_i(cfg_force_i), .clr_force_i(done_o),
        .wait_q(wait_q), .page_q(page_q), .force_q(force_q)
    );

    boot_addr_gen #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W),
                    .ABUS_W(ABUS_W), .HI_W(HI_W)) u_addr (
        .page_i(page_act_q), .idx_i(idx_q), .slot_i(slot_q),
        .len_phase_i(len_phase), .active_i(ext_strobe_o),
        .addr_o(ext_addr_o), .hi_o(ext_dhi_o)
    );

    boot_word_asm u_asm (
        .clk(clk), .rst_n(rst_n),
        .cap_en_i(acc_done && state_q == ST_FETCH_BYTE),
        .slot_i(slot_q), .byte_i(rd_byte), .word_o(ram_wdata_o)
    );

    // next state
    always_comb begin
        boot_state_e tgt;
        tgt     = ST_FETCH_BYTE;
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req_i) begin
                    state_d = ST_GRANT;
                    ret_d   = ST_IDLE;
                end else if (force_q) begin
                    state_d = ST_FETCH_LEN;
                end
            end
            ST_FETCH_LEN, ST_FETCH_BYTE: begin
                if (wcnt_q == '0) begin
                    if (state_q == ST_FETCH_BYTE && slot_q == LAST_SLOT)
                        tgt = ST_WRITE;
                    if (bus_req_i) begin
                        state_d = ST_GRANT;
                        ret_d   = tgt;
                    end else begin
                        state_d = tgt;
                    end
                end
            end
            ST_WRITE:  state_d = (idx_q == '0) ? ST_FINISH : ST_FETCH_BYTE;
            ST_GRANT:  if (!bus_req_i) state_d = ret_q;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // outputs
    always_comb begin
        ext_strobe_o = 1'b0;
        len_phase    = 1'b0;
        bus_gnt_o    = 1'b0;
        ram_we_o     = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_FETCH_LEN: begin
                ext_strobe_o = 1'b1;
                len_phase    = 1'b1;
            end
            ST_FETCH_BYTE: ext_strobe_o = 1'b1;
            ST_WRITE:      ram_we_o     = 1'b1;
            ST_GRANT:      bus_gnt_o    = 1'b1;
            ST_FINISH:     done_o       = 1'b1;
            default: ;
        endcase
    end

    assign ram_addr_o = idx_q;

    // datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q     <= '1;
            idx_q      <= '0;
            slot_q     <= '0;
            page_act_q <= '0;
        end else begin
            if (!fetching || wcnt_q == '0)
                wcnt_q <= wait_q;
            else
                wcnt_q <= wcnt_q - 1'b1;
            if (state_q == ST_IDLE && state_d == ST_FETCH_LEN)
                page_act_q <= page_q;
            if (state_q == ST_FETCH_LEN && wcnt_q == '0) begin
                idx_q  <= {rd_byte, {WPL_W{1'b1}}};
                slot_q <= '0;
            end
            if (state_q == ST_FETCH_BYTE && wcnt_q == '0 && slot_q != LAST_SLOT)
                slot_q <= slot_q + 1'b1;
            if (state_q == ST_WRITE) begin
                slot_q <= '0;
                if (idx_q != '0)
                    idx_q <= idx_q - 1'b1;
            end
        end
    end

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_strobe_o && wcnt_q != '0) |=>
        (ext_strobe_o && $stable(ext_addr_o) && $stable(ext_dhi_o)));

    // R9
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_strobe_o && bus_gnt_o));

    // R9
    grant_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_gnt_o) && $past(ext_strobe_o)) |-> $past(wcnt_q == '0));

    // R10
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt_o |-> $past(bus_req_i));

    // R12
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> !ram_we_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/sim_boot_page_loader.sv
module sim_boot_page_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_force = 1'b0, bus_req = 1'b0;
    logic [2:0]  cfg_wait = '0, cfg_page = '0;
    logic        force_o, bus_gnt, strobe, ram_we, done;
    logic [13:0] ext_addr;
    logic [1:0]  ext_dhi;
    logic [23:0] bus_din;
    logic [10:0] ram_addr;
    logic [23:0] ram_wdata;

    always #10 clk = ~clk;

    boot_page_loader u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_wait_i(cfg_wait), .cfg_page_i(cfg_page),
        .cfg_force_i(cfg_force), .force_o(force_o),
        .bus_req_i(bus_req), .bus_gnt_o(bus_gnt),
        .ext_strobe_o(strobe), .ext_addr_o(ext_addr), .ext_dhi_o(ext_dhi),
        .bus_din_i(bus_din),
        .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
        .done_o(done)
    );

    logic [7:0]  len_tab [8];
    int          n_chk = 0, n_fail = 0, cyc = 0;
    logic [2:0]  cur_page;
    int          cur_n, cur_wait, acc_k, wr_k, run;
    logic        prev_strobe = 1'b0, prev_we = 1'b0, mon_on = 1'b0;
    logic [15:0] prev_a16 = '0;
    wire  [15:0] a16 = {ext_dhi, ext_addr};

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        if (a[12:0] == 13'd0) return len_tab[a[15:13]];
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5a;
    endfunction

    assign bus_din = {~rom_byte(a16), rom_byte(a16), 8'h3c};

    function automatic logic [15:0] exp_addr(input int k);
        int j, i, s;
        if (k == 0) return {cur_page, 13'd0};
        j = k - 1;
        i = cur_n - 1 - j / 3;
        s = j % 3;
        return {cur_page, 13'(4 * i + 3 - s)};
    endfunction

    function automatic logic [23:0] exp_word(input int i);
        logic [15:0] b;
        b = {cur_page, 13'd0};
        return {rom_byte(b + 16'(4 * i + 1)), rom_byte(b + 16'(4 * i + 2)),
                rom_byte(b + 16'(4 * i + 3))};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // port monitor
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (prev_strobe && (!strobe || a16 != prev_a16))
                chk(run == cur_wait + 1, "R6 strobe width", run, cur_wait + 1);
            if (strobe && (!prev_strobe || a16 != prev_a16)) begin
                chk(a16 == exp_addr(acc_k), acc_k == 0 ? "R2 length byte address" : "R3 fetch order",
                    a16, exp_addr(acc_k));
                chk(ext_dhi == exp_addr(acc_k) >> 14, "R4 upper address on data lines",
                    ext_dhi, exp_addr(acc_k) >> 14);
                acc_k++;
                run = 1;
            end else if (strobe) begin
                run++;
            end
            if (!strobe && a16 != 16'd0)
                chk(0, "R4 address idle at zero", a16, 0);
            if (strobe && bus_gnt)
                chk(0, "R9 strobe with grant", 1, 0);
            if (ram_we) begin
                chk(ram_addr == 11'(cur_n - 1 - wr_k), "R5 RAM word address", ram_addr, cur_n - 1 - wr_k);
                chk(ram_wdata == exp_word(cur_n - 1 - wr_k), "R5 RAM word data",
                    ram_wdata, exp_word(cur_n - 1 - wr_k));
                wr_k++;
            end
            if (ram_we && prev_we)
                chk(0, "R12 back to back write", 1, 0);
            prev_strobe = strobe;
            prev_a16    = a16;
            prev_we     = ram_we;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic arm(input logic [2:0] pg, input int w);
        cur_page = pg;
        cur_wait = w;
        cur_n    = 8 * (int'(len_tab[pg]) + 1);
        acc_k    = 0;
        wr_k     = 0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        k = 0;
        while (!done && k < 8000) begin
            @(negedge clk);
            k++;
        end
        chk(done == 1'b1, "R8 done pulse seen", done, 1);
        chk(acc_k == 1 + 3 * cur_n, "R3 access count", acc_k, 1 + 3 * cur_n);
        chk(wr_k == cur_n, tag, wr_k, cur_n);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
        chk(force_o == 1'b0, "R8 force self clear", force_o, 0);
    endtask

    task automatic start_boot(input logic [2:0] pg, input int w);
        arm(pg, w);
        cfg_we = 1'b1; cfg_page = pg; cfg_wait = 3'(w); cfg_force = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_force = 1'b0;
        chk(force_o == 1'b1, "R7 force set by write", force_o, 1);
    endtask

    task automatic grant_cycle(input int hold);
        int k;
        bus_req = 1'b1;
        k = 0;
        while (!bus_gnt && k < cur_wait + 4) begin
            @(negedge clk);
            k++;
        end
        chk(bus_gnt == 1'b1, "R9 grant after byte", bus_gnt, 1);
        repeat (hold) @(negedge clk);
        chk(bus_gnt == 1'b1 && strobe == 1'b0, "R9 held grant keeps strobe low", {bus_gnt, strobe}, 2'b10);
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_gnt == 1'b0, "R10 grant release", bus_gnt, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < 8; p++) len_tab[p] = 8'($urandom_range(0, 2));
        arm(3'd0, 7);
        repeat (3) @(negedge clk);
        chk(strobe == 0 && bus_gnt == 0 && ram_we == 0 && done == 0, "R1 outputs idle in reset",
            {strobe, bus_gnt, ram_we, done}, 0);
        chk(force_o == 1'b1, "R1 force set in reset", force_o, 1);
        mon_on = 1'b1;
        rst_n  = 1'b1;
        wait_done("R1 reset boot of page 0");

        // R11: request while idle
        @(negedge clk);
        bus_req = 1'b1;
        @(negedge clk);
        chk(bus_gnt == 1'b1 && strobe == 1'b0, "R11 idle grant", {bus_gnt, strobe}, 2'b10);
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_gnt == 1'b0, "R10 idle grant release", bus_gnt, 0);
        repeat (3) @(negedge clk);
        chk(force_o == 1'b0 && strobe == 1'b0, "R11 no boot from grant", {force_o, strobe}, 0);

        // directed: zero wait states, top page
        start_boot(3'd7, 0);
        wait_done("R6 zero-wait boot word count");

        // directed collision: request raised in final wait cycle of an access
        start_boot(3'd5, 3);
        while (!strobe) @(negedge clk);
        while (strobe) @(negedge clk);
        while (!strobe) @(negedge clk);
        repeat (cur_wait) @(negedge clk);
        bus_req = 1'b1;
        @(negedge clk);
        chk(bus_gnt == 1'b1 && strobe == 1'b0, "R9 grant right after last wait cycle",
            {bus_gnt, strobe}, 2'b10);
        repeat (2) @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_gnt == 1'b0 && strobe == 1'b1, "R10 fetch resumes on release", {bus_gnt, strobe}, 2'b01);
        wait_done("R10 words after resumed load");

        // constrained random boots
        for (int r = 0; r < 8; r++) begin
            logic [2:0] pg;
            int w;
            pg = 3'($urandom_range(0, 7));
            w  = $urandom_range(0, 7);
            start_boot(pg, w);
            if (r % 2 == 0) begin
                repeat ($urandom_range(0, 15)) @(negedge clk);
                grant_cycle($urandom_range(1, 5));
                wait_done("R10 words with mid-boot grant");
            end else begin
                wait_done("R7 forced boot word count");
            end
            repeat (2) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule